// File: doc/BRIEF.md
# NAND Page Buffer Read-Out Unit

This unit owns the data bus of a NAND flash device model during read cycles. It answers every read strobe from one of three sources. The first is an identification sequence. The second is a status byte that does not move. The third is a stream of bytes taken from a one-page buffer. That buffer holds the main area of a page followed by its spare area. The command sequencer in front of the unit tells it which source is current. It does this with a command strobe that carries a command kind, a page/column address and a pending column offset.

When the page source is selected and no buffered bytes are left, the next read starts a fill of the buffer. The fill is requested from the storage block with a held request line and comes back as one byte per valid pulse. When the last byte of the page has arrived, the read is answered. The stream length depends on the start column and on the spare-exclude input. When the stream runs dry, the address moves on to column zero of the following page, so back-to-back reads run through consecutive pages.

Top module: `nrd_readout`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `io_out`, `rd_valid`, `busy` and `ld_req` are all zero.
- R2: After a command of kind 2'b01, the first four reads return the manufacturer code, then the device code, then 0x51, then the geometry byte. The geometry byte is 0x15 for a large-page 8-bit device, 0x55 for a large-page 16-bit device and 0xC0 for a small-page device. Every read after the fourth returns 0x00.
- R3: After a command of kind 2'b10, every read returns the status byte and nothing advances. In the status byte, bit 7 equals `wp_n` at the time of the read, bit 6 equals `busy`, bit 0 equals `err_flag`, and the other bits are zero.
- R4: A command of kind 2'b00 makes the address equal to `cmd_addr`. Bits above the column width hold the page and the low bits hold the column. It also makes the pending offset equal to `cmd_offset` and sets the count of remaining bytes to zero. The next read with `ce_n` low raises `ld_req` with `ld_page` set to that page, and holds `ld_page` steady until the fill ends. That read returns buffer byte column+offset. The pending offset is then zero for every later fill.
- R5: The number of bytes that a fill makes available is PAGE_BYTES minus the start column. When `spare_excl` is low at the fill, PAGE_BYTES/32 is added to that count. Only the read that follows the last available byte starts a new fill.
- R6: When the last available byte has been read, the address becomes column 0 of the next page, wrapping after the last page. The next fill requests that page.
- R7: A read with `ce_n` high returns 0x00 with `rd_valid` and changes no state. The read after it returns what this read would have returned.
- R8: Each page byte read moves the buffer pointer and the column up by one, so consecutive reads return consecutive buffer bytes.
- R9: A command strobe in the same cycle as a read strobe takes effect, and that read is dropped: no `rd_valid` follows it.
- R10: A read that needs no fill raises `rd_valid` in the next cycle. A read that needs a fill raises `rd_valid` in the cycle after the last fill byte is accepted. `rd_valid` is never high while `busy` is high.
- R11: After a command of kind 2'b11, reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_strobe | input | 1 | New command from the sequencer (ignored while busy) |
| cmd_kind | input | 2 | 00 page read, 01 identify, 10 status, 11 other |
| cmd_addr | input | PW+CW | Page (upper bits) and column (lower CW bits) |
| cmd_offset | input | CW | Pending column offset applied to the next fill |
| rd_strobe | input | 1 | Read cycle request (ignored while busy) |
| ce_n | input | 1 | Chip enable, active low |
| spare_excl | input | 1 | High: the stream excludes the spare area |
| wp_n | input | 1 | Write-protect pin, high when unprotected |
| err_flag | input | 1 | Error bit for the status byte |
| io_out | output | 8 | Read data |
| rd_valid | output | 1 | `io_out` holds the answer to a read |
| busy | output | 1 | Buffer fill in progress |
| ld_req | output | 1 | Page load request to storage |
| ld_page | output | PW | Page being loaded |
| fill_valid | input | 1 | Storage delivers one byte |
| fill_byte | input | 8 | Byte delivered by storage, in column order from 0 |

## Verification
A command strobe and a read strobe can land in the same cycle, and the two fight over the source selection. The bench raises both strobes on one edge while a page stream still has bytes left. It expects no `rd_valid` in the next cycle. It then expects the following read to return the status byte of the new command and not the next page byte. A further case puts a `wp_n` change right before status reads, to show that the status byte follows the pin and does not hold a copy of it.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

   typedef enum logic [1:0] {
      CMD_PAGE   = 2'b00,
      CMD_ID     = 2'b01,
      CMD_STATUS = 2'b10,
      CMD_OTHER  = 2'b11
   } nrd_cmd_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } nrd_state_e;

   localparam logic [7:0] ID_FILLER   = 8'h51;
   localparam int         ID_LENGTH   = 4;
   localparam int         SPARE_RATIO = 32;

endpackage

// File: rtl/nrd_buffer.sv
module nrd_buffer #(
   parameter int DEPTH = 66,
   parameter int AW    = 7
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = (raddr < AW'(DEPTH)) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/nrd_id_rom.sv
module nrd_id_rom
   import nrd_pkg::*;
#(
   parameter logic [7:0] MFR_CODE   = 8'hEC,
   parameter logic [7:0] DEV_CODE   = 8'hA1,
   parameter bit         LARGE_PAGE = 1'b1,
   parameter bit         BUS16      = 1'b0
) (
   input  logic [1:0] idx,
   output logic [7:0] id_byte
);
   logic [7:0] geom;

   if (LARGE_PAGE) begin : g_large
      if (BUS16) begin : g_wide
         assign geom = 8'h55;
      end else begin : g_narrow
         assign geom = 8'h15;
      end
   end else begin : g_small
      assign geom = 8'hC0;
   end

   always_comb begin
      unique case (idx)
         2'd0:    id_byte = MFR_CODE;
         2'd1:    id_byte = DEV_CODE;
         2'd2:    id_byte = ID_FILLER;
         default: id_byte = geom;
      endcase
   end
endmodule

// File: rtl/nrd_loader.sv
module nrd_loader #(
   parameter int TOTAL = 66,
   parameter int CW    = 7,
   parameter int PW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [PW-1:0] start_page,
   input  logic          fill_valid,
   output logic          ld_req,
   output logic [PW-1:0] ld_page,
   output logic          wr_en,
   output logic [CW-1:0] wr_idx,
   output logic          done
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_req  <= 1'b0;
         ld_page <= '0;
         cnt     <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            ld_req  <= 1'b1;
            ld_page <= start_page;
            cnt     <= '0;
         end else if (ld_req && fill_valid) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(TOTAL - 1)) begin
               ld_req <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign wr_en  = ld_req & fill_valid;
   assign wr_idx = cnt;
endmodule

// File: rtl/nrd_readout.sv
module nrd_readout
   import nrd_pkg::*;
#(
   parameter int         PAGE_BYTES = 64,
   parameter int         NUM_PAGES  = 4,
   parameter bit         LARGE_PAGE = 1'b1,
   parameter bit         BUS16      = 1'b0,
   parameter logic [7:0] MFR_CODE   = 8'hEC,
   parameter logic [7:0] DEV_CODE   = 8'hA1,
   localparam int SPARE_BYTES = PAGE_BYTES / SPARE_RATIO,
   localparam int TOTAL_BYTES = PAGE_BYTES + SPARE_BYTES,
   localparam int CW          = $clog2(TOTAL_BYTES),
   localparam int PW          = $clog2(NUM_PAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_strobe,
   input  logic [1:0]       cmd_kind,
   input  logic [PW+CW-1:0] cmd_addr,
   input  logic [CW-1:0]    cmd_offset,
   input  logic             rd_strobe,
   input  logic             ce_n,
   input  logic             spare_excl,
   input  logic             wp_n,
   input  logic             err_flag,
   output logic [7:0]       io_out,
   output logic             rd_valid,
   output logic             busy,
   output logic             ld_req,
   output logic [PW-1:0]    ld_page,
   input  logic             fill_valid,
   input  logic [7:0]       fill_byte
);
   if (PAGE_BYTES < SPARE_RATIO || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 32");
   end
   if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two of at least 2");
   end

   localparam logic [CW:0] LIM_MAIN = (CW+1)'(PAGE_BYTES);
   localparam logic [CW:0] LIM_FULL = (CW+1)'(TOTAL_BYTES);

   nrd_state_e    state;
   nrd_cmd_e      mode;
   logic [CW-1:0] col, pend_off, ptr;
   logic [PW-1:0] page;
   logic [CW:0]   remain;
   logic [2:0]    id_idx;

   logic [CW:0]   start_sum, lim, avail;
   logic [7:0]    buf_rd, id_byte, status_byte;
   logic          load_start, fill_done, wr_en;
   logic [CW-1:0] wr_idx;
   logic          rd_take;

   assign busy        = (state == ST_FILL);
   assign rd_take     = (state == ST_IDLE) && rd_strobe && !cmd_strobe;
   assign start_sum   = {1'b0, col} + {1'b0, pend_off};
   assign lim         = spare_excl ? LIM_MAIN : LIM_FULL;
   assign avail       = (start_sum < lim) ? (lim - start_sum) : '0;
   assign load_start  = rd_take && !ce_n && (mode == CMD_PAGE) && (remain == '0);
   assign status_byte = {wp_n, busy, 5'b00000, err_flag};

   nrd_buffer #(.DEPTH(TOTAL_BYTES), .AW(CW)) u_buf (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_idx),
      .wdata (fill_byte),
      .raddr (ptr),
      .rdata (buf_rd)
   );

   nrd_id_rom #(
      .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE),
      .LARGE_PAGE(LARGE_PAGE), .BUS16(BUS16)
   ) u_id (
      .idx     (id_idx[1:0]),
      .id_byte (id_byte)
   );

   nrd_loader #(.TOTAL(TOTAL_BYTES), .CW(CW), .PW(PW)) u_ld (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (load_start),
      .start_page (page),
      .fill_valid (fill_valid),
      .ld_req     (ld_req),
      .ld_page    (ld_page),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .done       (fill_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mode     <= CMD_OTHER;
         col      <= '0;
         page     <= '0;
         pend_off <= '0;
         ptr      <= '0;
         remain   <= '0;
         id_idx   <= '0;
         io_out   <= 8'h00;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         if (state == ST_IDLE && cmd_strobe) begin
            mode     <= nrd_cmd_e'(cmd_kind);
            col      <= cmd_addr[CW-1:0];
            page     <= cmd_addr[PW+CW-1:CW];
            pend_off <= cmd_offset;
            remain   <= '0;
            id_idx   <= '0;
         end else if (load_start) begin
            state    <= ST_FILL;
            ptr      <= start_sum[CW-1:0];
            remain   <= avail;
            pend_off <= '0;
         end else if (rd_take || (state == ST_FILL && fill_done)) begin
            state    <= ST_IDLE;
            rd_valid <= 1'b1;
            io_out   <= 8'h00;
            if (!ce_n || state == ST_FILL) begin
               unique case (mode)
                  CMD_PAGE: begin
                     if (remain != '0) begin
                        io_out <= buf_rd;
                        ptr    <= ptr + 1'b1;
                        remain <= remain - 1'b1;
                        if (remain == (CW+1)'(1)) begin
                           col  <= '0;
                           page <= page + 1'b1;
                        end else begin
                           col <= col + 1'b1;
                        end
                     end
                  end
                  CMD_ID: begin
                     if (id_idx < 3'(ID_LENGTH)) begin
                        io_out <= id_byte;
                        id_idx <= id_idx + 1'b1;
                     end
                  end
                  CMD_STATUS: io_out <= status_byte;
                  default:    io_out <= 8'h00;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/nrd_readout_chk.sv
module nrd_readout_chk #(
   parameter int PW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_strobe,
   input logic          rd_strobe,
   input logic          ce_n,
   input logic [7:0]    io_out,
   input logic          rd_valid,
   input logic          busy,
   input logic          ld_req,
   input logic [PW-1:0] ld_page
);
   AST_REQ_ONLY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |-> busy); // R4

   AST_LOAD_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && $past(ld_req)) |-> $stable(ld_page)); // R4

   AST_NO_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rd_valid); // R10

   AST_COLLISION_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_strobe && rd_strobe && !busy) |=> !rd_valid); // R9

   AST_DESELECTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && ce_n && !cmd_strobe && !busy) |=> (rd_valid && io_out == 8'h00)); // R7
endmodule

bind nrd_readout nrd_readout_chk #(.PW(PW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_strobe (cmd_strobe),
   .rd_strobe  (rd_strobe),
   .ce_n       (ce_n),
   .io_out     (io_out),
   .rd_valid   (rd_valid),
   .busy       (busy),
   .ld_req     (ld_req),
   .ld_page    (ld_page)
);

// File: tb/nrd_readout_test.sv
module nrd_readout_test;
   localparam int CLK_PERIOD = 10;
   localparam int PAGE  = 64;
   localparam int NPG   = 4;
   localparam int TOTAL = PAGE + PAGE / 32;
   localparam int CW    = $clog2(TOTAL);
   localparam int PW    = $clog2(NPG);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_strobe = 1'b0;
   logic [1:0] cmd_kind = 2'b11;
   logic [PW+CW-1:0] cmd_addr = '0;
   logic [CW-1:0] cmd_offset = '0;
   logic rd_strobe = 1'b0;
   logic ce_n = 1'b0;
   logic spare_excl = 1'b0;
   logic wp_n = 1'b1;
   logic err_flag = 1'b0;
   logic [7:0] io_out;
   logic rd_valid, busy, ld_req;
   logic [PW-1:0] ld_page;
   logic fill_valid = 1'b0;
   logic [7:0] fill_byte = 8'h00;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [7:0] exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   nrd_readout #(.PAGE_BYTES(PAGE), .NUM_PAGES(NPG), .LARGE_PAGE(1'b1), .BUS16(1'b0),
                 .MFR_CODE(8'hEC), .DEV_CODE(8'hA1)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_kind(cmd_kind),
      .cmd_addr(cmd_addr), .cmd_offset(cmd_offset), .rd_strobe(rd_strobe),
      .ce_n(ce_n), .spare_excl(spare_excl), .wp_n(wp_n), .err_flag(err_flag),
      .io_out(io_out), .rd_valid(rd_valid), .busy(busy), .ld_req(ld_req),
      .ld_page(ld_page), .fill_valid(fill_valid), .fill_byte(fill_byte));

   function automatic logic [7:0] fb(input int pg, input int idx);
      return 8'((pg * 49 + idx * 7 + 5) & 255);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // storage model: one byte per cycle in column order while requested
   int scnt = 0;
   always @(negedge clk) begin
      if (ld_req && scnt < TOTAL) begin
         fill_valid <= 1'b1;
         fill_byte  <= fb(int'(ld_page), scnt);
         scnt       <= scnt + 1;
      end else begin
         fill_valid <= 1'b0;
         if (!ld_req) scnt <= 0;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected rd_valid", int'(io_out), 0);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(io_out == e, t, int'(io_out), int'(e));
         end
      end
   end

   task automatic send_cmd(input logic [1:0] kind, input int pg, input int c, input int off);
      @(negedge clk);
      cmd_strobe = 1'b1;
      cmd_kind   = kind;
      cmd_addr   = {PW'(pg), CW'(c)};
      cmd_offset = CW'(off);
      @(negedge clk);
      cmd_strobe = 1'b0;
   endtask

   task automatic do_read(input logic [7:0] exp, input string tag,
                          input bit immediate, input bit expect_load, input int exp_page);
      @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      if (immediate)
         check(rd_valid == 1'b1 && ld_req == 1'b0, {tag, " R10 latency"}, int'(rd_valid), 1);
      if (expect_load)
         check(ld_req == 1'b1 && int'(ld_page) == exp_page, {tag, " R5 load request"},
               int'(ld_page), exp_page);
      while (busy) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(io_out == 8'h00 && rd_valid == 1'b0, "R1 reset outputs", int'(io_out), 0);
      check(busy == 1'b0 && ld_req == 1'b0, "R1 reset busy/req", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rd_valid == 1'b0 && busy == 1'b0 && ld_req == 1'b0, "R1 after reset",
            int'(ld_req), 0);

      // R11 other command
      send_cmd(2'b11, 0, 0, 0);
      do_read(8'h00, "R11 other cmd", 1'b1, 1'b0, 0);

      // R2 identification sequence
      send_cmd(2'b01, 0, 0, 0);
      do_read(8'hEC, "R2 id byte0", 1'b1, 1'b0, 0);
      do_read(8'hA1, "R2 id byte1", 1'b1, 1'b0, 0);
      do_read(8'h51, "R2 id byte2", 1'b1, 1'b0, 0);
      do_read(8'h15, "R2 id byte3", 1'b1, 1'b0, 0);
      do_read(8'h00, "R2 id past end", 1'b1, 1'b0, 0);

      // R4/R5/R8/R6 page 1 column 5, spare included: 61 bytes then next page
      spare_excl = 1'b0;
      send_cmd(2'b00, 1, 5, 0);
      do_read(fb(1, 5), "R4 first byte after fill", 1'b0, 1'b1, 1);
      for (int i = 6; i < TOTAL; i++)
         do_read(fb(1, i), "R8 consecutive page byte", 1'b1, 1'b0, 0);
      do_read(fb(2, 0), "R6 next page column 0", 1'b0, 1'b1, 2);

      // R5/R4 spare excluded, column 60 plus offset 2 gives two bytes
      spare_excl = 1'b1;
      send_cmd(2'b00, 3, 60, 2);
      do_read(fb(3, 62), "R4 offset start", 1'b0, 1'b1, 3);
      do_read(fb(3, 63), "R5 last main byte", 1'b1, 1'b0, 0);
      do_read(fb(0, 0), "R6 wrap, R4 offset cleared", 1'b0, 1'b1, 0);
      do_read(fb(0, 1), "R8 after wrap", 1'b1, 1'b0, 0);

      // R7 deselected read changes nothing
      ce_n = 1'b1;
      do_read(8'h00, "R7 deselected zero", 1'b1, 1'b0, 0);
      ce_n = 1'b0;
      do_read(fb(0, 2), "R7 no advance", 1'b1, 1'b0, 0);

      // R9 command and read in one cycle
      @(negedge clk);
      cmd_strobe = 1'b1;
      cmd_kind   = 2'b10;
      rd_strobe  = 1'b1;
      @(negedge clk);
      cmd_strobe = 1'b0;
      rd_strobe  = 1'b0;
      check(rd_valid == 1'b0, "R9 read dropped", int'(rd_valid), 0);

      // R3 status sticky and live
      wp_n = 1'b1;
      err_flag = 1'b0;
      do_read(8'h80, "R3 status after collision", 1'b1, 1'b0, 0);
      do_read(8'h80, "R3 status repeat", 1'b1, 1'b0, 0);
      wp_n = 1'b0;
      do_read(8'h00, "R3 status protected", 1'b1, 1'b0, 0);
      err_flag = 1'b1;
      do_read(8'h01, "R3 status error", 1'b1, 1'b0, 0);
      wp_n = 1'b1;
      do_read(8'h81, "R3 status both", 1'b1, 1'b0, 0);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule